// File: doc/BRIEF.md
# Dual-Slope PWM Compare Output Stage

This block drives one waveform pin of an up/down timer that runs in one of its dual-slope PWM modes. On each counter tick it compares the running count with the active compare value. When they are equal, it sets, clears or inverts its registered output. The action depends on a 2-bit output-action selector and on whether the counter is rising or falling. A connect flag tells the surrounding pin multiplexer whether the waveform owns the pin or the pin is left to ordinary port use.

Two corner cases are resolved explicitly. A compare value equal to the period's turning point (TOP) gives a constant output level for the whole period, with no narrow pulse at the turn. A compare value of zero gives the opposite constant level. A parameter chooses between the channel flavour that supports the invert-on-match option and the flavour that does not. The counter, single-slope modes and forced-compare strobes belong to neighbouring blocks.

Top module: `dsp_pwm_out`

## Requirements
- R1: After reset the output `pin_q` is 0.
- R2: With `cmo_sel` = 2'b00, `pin_conn` is 0 and `pin_q` keeps its value through any tick or match.
- R3: With `cmo_sel` = 2'b01, on the channel built with `CHAN_A` = 1 and `wave_mode` in 8..11, `pin_conn` is 1 and `pin_q` inverts one cycle after every tick on which `cnt_val` equals `cmp_val`.
- R4: With `cmo_sel` = 2'b01 on a channel built with `CHAN_A` = 0, or with any `wave_mode` outside 8..11, `pin_conn` is 0 and `pin_q` keeps its value.
- R5: With `cmo_sel` = 2'b10 and a compare value that is neither 0 nor TOP, a match becomes `pin_q` = 0 while `cnt_up` = 1 and `pin_q` = 1 while `cnt_up` = 0. `pin_conn` is 1.
- R6: With `cmo_sel` = 2'b11 and a compare value that is neither 0 nor TOP, a match becomes `pin_q` = 1 while `cnt_up` = 1 and `pin_q` = 0 while `cnt_up` = 0. `pin_conn` is 1.
- R7: When `cmp_val` equals `top_val` and `cmo_sel[1]` = 1, a match gives `pin_q` = NOT `cmo_sel[0]` in either direction (constant high for 2'b10, constant low for 2'b11).
- R8: When `cmp_val` is 0, differs from `top_val`, and `cmo_sel[1]` = 1, a match gives `pin_q` = `cmo_sel[0]` in either direction.
- R9: `pin_q` changes only in the cycle after a clock edge at which `tick_en` = 1 and `cnt_val` equals `cmp_val`.
- R10: Changing `cmo_sel` does not change `pin_q` until the next match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advances this cycle; matches are evaluated only then |
| cnt_val | input | WIDTH | Current counter value |
| cnt_up | input | 1 | 1 = counter rising, 0 = falling |
| cmp_val | input | WIDTH | Active (buffered) compare value |
| top_val | input | WIDTH | Current period turning point |
| wave_mode | input | 4 | Waveform generation mode number |
| cmo_sel | input | 2 | Output action selector |
| pin_q | output | 1 | Registered waveform level |
| pin_conn | output | 1 | 1 = waveform drives the pin, 0 = normal port use |

## Verification
The bench builds two copies with `WIDTH` = 10. One has `CHAN_A` = 1 and the other has `CHAN_A` = 0, and both receive the same stimulus. This lets the invert-on-match option, and its absence on the second channel, be compared in the same cycle. A 10-bit count keeps the compare values cheap to drive. A TOP of 20 still leaves room for matches at zero, at TOP and in between, in both count directions.

// File: rtl/dsp_pwm_pkg.sv
package dsp_pwm_pkg;

   typedef enum logic [1:0] {
      CMO_OFF    = 2'b00,
      CMO_FLIP   = 2'b01,
      CMO_CLR_UP = 2'b10,
      CMO_SET_UP = 2'b11
   } cmo_e;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'b00,
      ACT_CLR  = 2'b01,
      ACT_SET  = 2'b10,
      ACT_INV  = 2'b11
   } act_e;

   localparam logic [3:0] FLIP_MODE_LO = 4'd8;
   localparam logic [3:0] FLIP_MODE_HI = 4'd11;

   function automatic logic mode_allows_flip(input logic [3:0] wm);
      return (wm >= FLIP_MODE_LO) && (wm <= FLIP_MODE_HI);
   endfunction

endpackage

// File: rtl/dsp_match.sv
module dsp_match #(
   parameter int WIDTH = 16
) (
   input  logic             tick_en,
   input  logic [WIDTH-1:0] cnt_val,
   input  logic [WIDTH-1:0] cmp_val,
   input  logic [WIDTH-1:0] top_val,
   output logic             hit,
   output logic             cmp_is_top,
   output logic             cmp_is_zero
);
   localparam logic [WIDTH-1:0] ZERO = '0;

   always_comb begin
      hit         = tick_en && (cnt_val == cmp_val);
      cmp_is_top  = (cmp_val == top_val);
      cmp_is_zero = (cmp_val == ZERO);
   end
endmodule

// File: rtl/dsp_action.sv
module dsp_action
   import dsp_pwm_pkg::*;
#(
   parameter bit CHAN_A = 1'b1
) (
   input  logic [1:0] cmo_sel,
   input  logic [3:0] wave_mode,
   input  logic       cnt_up,
   input  logic       hit,
   input  logic       cmp_is_top,
   input  logic       cmp_is_zero,
   output act_e       act,
   output logic       conn
);
   logic flip_ok;
   logic flip_mode;
   cmo_e sel;

   assign sel       = cmo_e'(cmo_sel);
   assign flip_mode = mode_allows_flip(wave_mode);

   generate
      if (CHAN_A) begin : g_flip
         assign flip_ok = flip_mode;
      end else begin : g_noflip
         assign flip_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         CMO_OFF:  conn = 1'b0;
         CMO_FLIP: conn = flip_ok;
         default:  conn = 1'b1;
      endcase
   end

   // Level applied on a match in the slope-dependent selections
   logic lvl;
   always_comb begin
      if (cmp_is_top)       lvl = ~cmo_sel[0];
      else if (cmp_is_zero) lvl = cmo_sel[0];
      else if (cnt_up)      lvl = cmo_sel[0];
      else                  lvl = ~cmo_sel[0];
   end

   always_comb begin
      act = ACT_HOLD;
      if (hit) begin
         unique case (sel)
            CMO_OFF:  act = ACT_HOLD;
            CMO_FLIP: act = flip_ok ? ACT_INV : ACT_HOLD;
            default:  act = lvl ? ACT_SET : ACT_CLR;
         endcase
      end
   end
endmodule

// File: rtl/dsp_outreg.sv
module dsp_outreg
   import dsp_pwm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  act_e act,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else begin
         unique case (act)
            ACT_HOLD: q <= q;
            ACT_CLR:  q <= 1'b0;
            ACT_SET:  q <= 1'b1;
            ACT_INV:  q <= ~q;
         endcase
      end
   end

   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_HOLD) |=> $stable(q));
   assert_inv_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_INV) |=> (q != $past(q)));
endmodule

// File: rtl/dsp_pwm_out.sv
module dsp_pwm_out
   import dsp_pwm_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter bit CHAN_A = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [WIDTH-1:0] cnt_val,
   input  logic             cnt_up,
   input  logic [WIDTH-1:0] cmp_val,
   input  logic [WIDTH-1:0] top_val,
   input  logic [3:0]       wave_mode,
   input  logic [1:0]       cmo_sel,
   output logic             pin_q,
   output logic             pin_conn
);
   localparam int MIN_W = 2;
   localparam int MAX_W = 32;

   generate
      if (WIDTH < MIN_W || WIDTH > MAX_W) begin : g_bad_width
         $error("dsp_pwm_out: WIDTH out of supported range");
      end
   endgenerate

   logic hit, cmp_is_top, cmp_is_zero;
   act_e act;

   dsp_match #(.WIDTH(WIDTH)) u_match (
      .tick_en     (tick_en),
      .cnt_val     (cnt_val),
      .cmp_val     (cmp_val),
      .top_val     (top_val),
      .hit         (hit),
      .cmp_is_top  (cmp_is_top),
      .cmp_is_zero (cmp_is_zero)
   );

   dsp_action #(.CHAN_A(CHAN_A)) u_action (
      .cmo_sel     (cmo_sel),
      .wave_mode   (wave_mode),
      .cnt_up      (cnt_up),
      .hit         (hit),
      .cmp_is_top  (cmp_is_top),
      .cmp_is_zero (cmp_is_zero),
      .act         (act),
      .conn        (pin_conn)
   );

   dsp_outreg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .q     (pin_q)
   );

   assert_off_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmo_sel == 2'b00) |=> $stable(pin_q));
   assert_off_disc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmo_sel == 2'b00) |-> !pin_conn);
   assert_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(pin_q));
   assert_top_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && cmo_sel[1] && cnt_val == cmp_val && cmp_val == top_val)
      |=> (pin_q == !$past(cmo_sel[0])));
   assert_clr_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && cmo_sel == 2'b10 && cnt_up && cnt_val == cmp_val
       && cmp_val != top_val && cmp_val != '0) |=> !pin_q);
endmodule

// File: tb/dsp_pwm_out_tb.sv
module dsp_pwm_out_tb_top;
   localparam int W = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0;
   logic [W-1:0] cnt_val = '0, cmp_val = '0, top_val = '0;
   logic cnt_up = 1'b1;
   logic [3:0] wave_mode = 4'd1;
   logic [1:0] cmo_sel = 2'b00;
   logic qa, ca, qb, cb;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   dsp_pwm_out #(.WIDTH(W), .CHAN_A(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_val(cnt_val),
      .cnt_up(cnt_up), .cmp_val(cmp_val), .top_val(top_val),
      .wave_mode(wave_mode), .cmo_sel(cmo_sel), .pin_q(qa), .pin_conn(ca));

   dsp_pwm_out #(.WIDTH(W), .CHAN_A(1'b0)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_val(cnt_val),
      .cnt_up(cnt_up), .cmp_val(cmp_val), .top_val(top_val),
      .wave_mode(wave_mode), .cmo_sel(cmo_sel), .pin_q(qb), .pin_conn(cb));

   typedef struct {
      logic  qa, ca, qb, cb;
      string tag;
   } exp_t;

   exp_t sb[$];
   logic mqa = 1'b0, mqb = 1'b0;

   task automatic chk(input logic act, input logic exp, input string what, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic tk, input int cnt, input logic up, input int cmp,
                       input int top, input int wm, input logic [1:0] cm, input string tag);
      exp_t e;
      logic hit, lvl, fa;
      @(negedge clk);
      tick_en = tk; cnt_val = W'(cnt); cnt_up = up; cmp_val = W'(cmp);
      top_val = W'(top); wave_mode = 4'(wm); cmo_sel = cm;
      hit = tk && (cnt == cmp);
      fa  = (wm >= 8) && (wm <= 11);
      e.ca = (cm == 2'b01) ? fa : (cm != 2'b00);
      e.cb = cm[1];
      if (hit) begin
         if (cm[1]) begin
            if (cmp == top)    lvl = ~cm[0];
            else if (cmp == 0) lvl = cm[0];
            else               lvl = up ? cm[0] : ~cm[0];
            mqa = lvl; mqb = lvl;
         end else if (cm == 2'b01 && fa) begin
            mqa = ~mqa;
         end
      end
      e.qa = mqa; e.qb = mqb; e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(qa, e.qa, "A level", e.tag);
            chk(ca, e.ca, "A conn",  e.tag);
            chk(qb, e.qb, "B level", e.tag);
            chk(cb, e.cb, "B conn",  e.tag);
         end
      end
   end

   initial begin : watchdog
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #1;
      chk(qa, 1'b0, "reset level A", "R1");
      chk(qb, 1'b0, "reset level B", "R1");
      @(negedge clk);
      rst_n = 1'b1;
      // R2: disconnected selection ignores matches
      step(1, 5, 1, 5, 20, 1, 2'b00, "R2");
      // R5: clear up, set down
      step(1, 5, 0, 5, 20, 1, 2'b10, "R5");
      step(1, 6, 0, 5, 20, 1, 2'b10, "R9");
      step(0, 5, 1, 5, 20, 1, 2'b10, "R9");
      step(1, 5, 1, 5, 20, 1, 2'b10, "R5");
      // R6: set up, clear down
      step(1, 7, 1, 7, 20, 1, 2'b11, "R6");
      step(1, 7, 0, 7, 20, 1, 2'b11, "R6");
      // R10: selector change without match keeps level
      step(1, 8, 1, 7, 20, 1, 2'b10, "R10");
      step(1, 3, 0, 7, 20, 1, 2'b00, "R10");
      step(1, 7, 0, 7, 20, 1, 2'b10, "R5");
      step(1, 9, 1, 7, 20, 1, 2'b11, "R10");
      // R7: compare at TOP, constant level
      step(1, 20, 1, 20, 20, 1, 2'b11, "R7");
      step(1, 20, 0, 20, 20, 1, 2'b10, "R7");
      step(1, 20, 1, 20, 20, 1, 2'b10, "R7");
      step(1, 20, 0, 20, 20, 1, 2'b11, "R7");
      // R8: compare at zero, opposite constant
      step(1, 0, 0, 0, 20, 1, 2'b11, "R8");
      step(1, 0, 1, 0, 20, 1, 2'b10, "R8");
      step(1, 0, 0, 0, 20, 1, 2'b10, "R8");
      // R3: invert on match, channel A only
      step(1, 4, 1, 4, 20, 9, 2'b01, "R3");
      step(1, 4, 0, 4, 20, 8, 2'b01, "R3");
      step(1, 5, 0, 4, 20, 10, 2'b01, "R3");
      step(1, 4, 1, 4, 20, 11, 2'b01, "R3");
      // R4: no inversion outside modes 8..11
      step(1, 4, 1, 4, 20, 3, 2'b01, "R4");
      step(1, 4, 0, 4, 20, 12, 2'b01, "R4");
      step(1, 4, 1, 4, 20, 10, 2'b01, "R4");
      step(0, 4, 1, 4, 20, 10, 2'b01, "R9");
      repeat (3) @(posedge clk);
      #1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule